// File: doc/BRIEF.md
# 12-bit ALU with masked status flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes a destination operand `d`, a source operand `s`, an operation code and the current carry. It returns the result, a write-enable that says whether the result goes back to `d`, and the next values of the four status flags. A mask marks which flags the operation updates. Operand fetch, addressing modes, the decimal add and the multiply belong to other blocks.

The datapath is combinational. The one piece of state is a rotate-count register. A separate operation loads a count into it, and the next rotate that is executed uses that count. Loading a count of zero takes the count from the low four bits of an auxiliary register instead. When a rotate uses the count, the register returns to its default of one.

Top module: `alu12_flagged`

## Requirements
- R1: Operation codes are MOV=0, AND=1, OR=2, EOR=3, ADD=4, ADDC=5, SUB=6, CMP=7, INC=8, DEC=9, ROR=10, ROL=11, RRC=12, RLC=13, RAR=14, PRSG=15, INV=16, NEG=17, TST=18. `wr_en_o` is 1 for every one of these except CMP and TST. Codes 19 to 31 give result 0, no write, and a zero flag mask.
- R2: MOV and TST give `s`. AND, OR and EOR give the bitwise result of `d` and `s`. INV gives NOT `d`. All six have flag mask 4'b0110, which updates N and Z only.
- R3: ADD gives d+s and ADDC gives d+s+carry_i. C is the carry out of bit 11. V is 1 when the sum lies outside -2048..2047 as a signed value. The mask is 4'b1111.
- R4: SUB and CMP compute d + (NOT s) + 1, so C=1 means no borrow. V is the signed overflow of that three-term sum. The mask is 4'b1111, and CMP does not write.
- R5: INC gives d+1, DEC gives d+0xFFF, and NEG gives (NOT d)+1. C is the carry out of that addition. The mask is 4'b0111.
- R6: `flags_o` is {V,N,Z,C} with V as bit 3. N is bit 11 of the result and Z is 1 when the result is zero. Any bit outside the mask reads as 0.
- R7: ROR and ROL rotate `d` by the current count. Each step moves the outgoing bit into both the opposite end and C. The mask is 4'b0111.
- R8: RRC and RLC rotate the 13-bit value formed by the carry and `d`, by the current count. The mask is 4'b0111.
- R9: RAR shifts `d` right by the current count, keeping bit 11 unchanged. C is the last bit shifted out. The mask is 4'b0111.
- R10: PRSG shifts `d` left by one bit, whatever the count. The new bit 0 is d[11]^d[5]^d[3]^d[0] and C is the old d[11]. The mask is 4'b0111.
- R11: The count register resets to 1. A clock edge with `rcnt_load_i` high loads `rcnt_val_i`, or `aux_cnt_i` when `rcnt_val_i` is 0. Otherwise an edge with `exec_i` high and a rotate (ROR, ROL, RRC, RLC, RAR) selected returns the count to 1. A load takes priority over this return.
- R12: A rotate with a count of 0 returns `d` unchanged, with C equal to `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| d_i | input | 12 | Destination operand |
| s_i | input | 12 | Source operand |
| carry_i | input | 1 | Current carry flag |
| exec_i | input | 1 | The operation executes this cycle |
| rcnt_load_i | input | 1 | Load the rotate count |
| rcnt_val_i | input | 4 | Rotate count to load, 0 selects aux |
| aux_cnt_i | input | 4 | Auxiliary register bits 3:0 |
| res_o | output | 12 | Result |
| wr_en_o | output | 1 | Result is written back |
| flags_o | output | 4 | Next {V,N,Z,C}, masked |
| flag_mask_o | output | 4 | Flags updated by this operation |

## Verification
Every defined operation is run over the full cross of the signed boundary values 0x000, 0x7FF, 0x800 and 0xFFF for both operands, with the carry both clear and set. This separates signed overflow from unsigned carry and separates the different borrow conventions. A long random run mixes all 32 codes with random count loads and random `exec_i`, so rotate results depend on the history of the count register. Short directed sequences cover count reload, load priority, a rotate that is not executed, and rotation by zero.

// File: rtl/alu12_pkg.sv
package alu12_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_MOV  = 5'd0,  OP_AND  = 5'd1,  OP_OR   = 5'd2,  OP_EOR  = 5'd3,
    OP_ADD  = 5'd4,  OP_ADDC = 5'd5,  OP_SUB  = 5'd6,  OP_CMP  = 5'd7,
    OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_ROR  = 5'd10, OP_ROL  = 5'd11,
    OP_RRC  = 5'd12, OP_RLC  = 5'd13, OP_RAR  = 5'd14, OP_PRSG = 5'd15,
    OP_INV  = 5'd16, OP_NEG  = 5'd17, OP_TST  = 5'd18
  } op_e;

  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_C = 0;

  localparam logic [3:0] MASK_NZ   = 4'b0110;
  localparam logic [3:0] MASK_NZC  = 4'b0111;
  localparam logic [3:0] MASK_VNZC = 4'b1111;

  function automatic logic is_rot(op_e op);
    return op inside {OP_ROR, OP_ROL, OP_RRC, OP_RLC, OP_RAR};
  endfunction
endpackage

// File: rtl/alu12_rcnt.sv
module alu12_rcnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] aux_i,
  input  logic          consume_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_DFLT = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= CNT_DFLT;
    else if (load_i)    cnt_q <= (val_i == '0) ? aux_i : val_i;
    else if (consume_i) cnt_q <= CNT_DFLT;
  end

  assign cnt_o = cnt_q;

  p_cnt_default_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !load_i |=> cnt_o == CNT_DFLT);
  p_cnt_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && val_i != '0 |=> cnt_o == $past(val_i));
  p_cnt_aux_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && val_i == '0 |=> cnt_o == $past(aux_i));
  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !consume_i |=> $stable(cnt_o));
endmodule

// File: rtl/alu12_arith.sv
module alu12_arith
  import alu12_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  op_e          op_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] s_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o,
  output logic         hit_o
);
  logic [W-1:0] a, b;
  logic         cin, use_add;
  logic [W:0]   sum;

  always_comb begin
    a       = d_i;
    b       = '0;
    cin     = 1'b0;
    use_add = 1'b0;
    hit_o   = 1'b1;
    res_o   = '0;
    v_o     = 1'b0;
    c_o     = 1'b0;
    case (op_i)
      OP_MOV, OP_TST: res_o = s_i;
      OP_AND:  res_o = d_i & s_i;
      OP_OR:   res_o = d_i | s_i;
      OP_EOR:  res_o = d_i ^ s_i;
      OP_INV:  res_o = ~d_i;
      OP_ADD:  begin use_add = 1'b1; b = s_i; end
      OP_ADDC: begin use_add = 1'b1; b = s_i; cin = c_i; end
      OP_SUB, OP_CMP: begin use_add = 1'b1; b = ~s_i; cin = 1'b1; end
      OP_INC:  begin use_add = 1'b1; cin = 1'b1; end
      OP_DEC:  begin use_add = 1'b1; b = '1; end
      OP_NEG:  begin use_add = 1'b1; a = ~d_i; cin = 1'b1; end
      default: hit_o = 1'b0;
    endcase
    // single shared adder for the whole add family
    sum = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
    if (use_add) begin
      res_o = sum[W-1:0];
      c_o   = sum[W];
      v_o   = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
  end
endmodule

// File: rtl/alu12_shift.sv
module alu12_shift
  import alu12_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 4
) (
  input  op_e           op_i,
  input  logic [W-1:0]  d_i,
  input  logic          c_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  res_o,
  output logic          c_o,
  output logic          hit_o
);
  localparam int unsigned STEPS = (1 << CW) - 1;
  localparam int unsigned TAP_A = 5;
  localparam int unsigned TAP_B = 3;

  logic [W-1:0] r;
  logic         c, nc;

  always_comb begin
    r     = d_i;
    c     = c_i;
    nc    = c_i;
    hit_o = 1'b1;
    if (is_rot(op_i)) begin
      for (int i = 0; i < STEPS; i++) begin
        if (i < int'(cnt_i)) begin
          nc = c;
          case (op_i)
            OP_ROR: begin nc = r[0];   r = {r[0], r[W-1:1]};   end
            OP_ROL: begin nc = r[W-1]; r = {r[W-2:0], r[W-1]}; end
            OP_RRC: begin nc = r[0];   r = {c, r[W-1:1]};      end
            OP_RLC: begin nc = r[W-1]; r = {r[W-2:0], c};      end
            OP_RAR: begin nc = r[0];   r = {r[W-1], r[W-1:1]}; end
            default: nc = c;
          endcase
          c = nc;
        end
      end
    end else if (op_i == OP_PRSG) begin
      c = d_i[W-1];
      r = {d_i[W-2:0], d_i[W-1] ^ d_i[TAP_A] ^ d_i[TAP_B] ^ d_i[0]};
    end else begin
      hit_o = 1'b0;
      r     = '0;
      c     = 1'b0;
    end
    res_o = r;
    c_o   = c;
  end
endmodule

// File: rtl/alu12_flagged.sv
module alu12_flagged
  import alu12_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    op_i,
  input  logic [W-1:0]  d_i,
  input  logic [W-1:0]  s_i,
  input  logic          carry_i,
  input  logic          exec_i,
  input  logic          rcnt_load_i,
  input  logic [CW-1:0] rcnt_val_i,
  input  logic [CW-1:0] aux_cnt_i,
  output logic [W-1:0]  res_o,
  output logic          wr_en_o,
  output logic [3:0]    flags_o,
  output logic [3:0]    flag_mask_o
);
  op_e           op;
  logic [CW-1:0] cnt;
  logic [W-1:0]  a_res, s_res, res;
  logic          a_v, a_c, a_hit, s_c, s_hit;
  logic [3:0]    mask, raw;

  assign op = op_e'(op_i);

  alu12_rcnt #(.CW(CW)) i_rcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rcnt_load_i),
    .val_i    (rcnt_val_i),
    .aux_i    (aux_cnt_i),
    .consume_i(exec_i && is_rot(op)),
    .cnt_o    (cnt)
  );

  alu12_arith #(.W(W)) i_arith (
    .op_i (op),
    .d_i  (d_i),
    .s_i  (s_i),
    .c_i  (carry_i),
    .res_o(a_res),
    .v_o  (a_v),
    .c_o  (a_c),
    .hit_o(a_hit)
  );

  alu12_shift #(.W(W), .CW(CW)) i_shift (
    .op_i (op),
    .d_i  (d_i),
    .c_i  (carry_i),
    .cnt_i(cnt),
    .res_o(s_res),
    .c_o  (s_c),
    .hit_o(s_hit)
  );

  always_comb begin
    case (op)
      OP_MOV, OP_AND, OP_OR, OP_EOR, OP_INV, OP_TST: mask = MASK_NZ;
      OP_ADD, OP_ADDC, OP_SUB, OP_CMP:               mask = MASK_VNZC;
      OP_INC, OP_DEC, OP_NEG, OP_PRSG,
      OP_ROR, OP_ROL, OP_RRC, OP_RLC, OP_RAR:        mask = MASK_NZC;
      default:                                       mask = 4'b0000;
    endcase
  end

  assign res = a_hit ? a_res : (s_hit ? s_res : '0);

  always_comb begin
    raw        = '0;
    raw[FLG_V] = a_hit & a_v;
    raw[FLG_N] = res[W-1];
    raw[FLG_Z] = (res == '0);
    raw[FLG_C] = a_hit ? a_c : s_c;
  end

  assign res_o       = res;
  assign flags_o     = raw & mask;
  assign flag_mask_o = mask;
  assign wr_en_o     = (a_hit || s_hit) && !(op inside {OP_CMP, OP_TST});

  p_unit_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_hit, s_hit}));
  p_no_write_cmp_tst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd7 || op_i == 5'd18) |-> !wr_en_o);
  p_undef_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > 5'd18 |-> !wr_en_o && flag_mask_o == 4'b0000 && res_o == '0);
  p_logic_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i <= 5'd3 |-> !flag_mask_o[FLG_V] && !flag_mask_o[FLG_C]);
  p_sub_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd6 || op_i == 5'd7) |-> flag_mask_o == 4'b1111);
  p_n_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_mask_o[FLG_N] |-> flags_o[FLG_N] == res_o[W-1]);
  p_z_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_mask_o[FLG_Z] |-> flags_o[FLG_Z] == (res_o == '0));
  p_zero_count_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_hit && op != OP_PRSG && cnt == '0 |-> res_o == d_i && flags_o[FLG_C] == carry_i);
endmodule

// File: tb/test_alu12_flagged.sv
`timescale 1ns/1ps
module test_alu12_flagged;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [11:0] d = '0, s = '0;
  logic        cin = 1'b0, ex = 1'b0, ld = 1'b0;
  logic [3:0]  val = '0, aux = '0;
  logic [11:0] res;
  logic        wr;
  logic [3:0]  flags, mask;

  int n_chk = 0, n_err = 0;
  int mcnt = 1;

  always #2.5 clk = ~clk;

  alu12_flagged i_alu12_flagged (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .d_i(d), .s_i(s), .carry_i(cin),
    .exec_i(ex), .rcnt_load_i(ld), .rcnt_val_i(val), .aux_cnt_i(aux),
    .res_o(res), .wr_en_o(wr), .flags_o(flags), .flag_mask_o(mask)
  );

  function automatic int sx(int v);
    return (v & 'h800) ? v - 4096 : v;
  endfunction

  function automatic bit ovf(int v);
    return v > 2047 || v < -2048;
  endfunction

  function automatic int pack_exp(int o, int dv, int sv, int c, int k);
    int r = 0, wrv = 1, m = 0, v = 0, cy = 0, sum;
    case (o)
      0, 18: begin r = sv; m = 'b0110; end
      1:  begin r = dv & sv; m = 'b0110; end
      2:  begin r = dv | sv; m = 'b0110; end
      3:  begin r = dv ^ sv; m = 'b0110; end
      16: begin r = (~dv) & 'hfff; m = 'b0110; end
      4, 5: begin
        sum = dv + sv + ((o == 5) ? c : 0);
        r = sum & 'hfff; cy = sum >> 12; m = 'b1111;
        v = ovf(sx(dv) + sx(sv) + ((o == 5) ? c : 0));
      end
      6, 7: begin
        sum = dv + ((~sv) & 'hfff) + 1;
        r = sum & 'hfff; cy = sum >> 12; m = 'b1111;
        v = ovf(sx(dv) + sx((~sv) & 'hfff) + 1);
      end
      8:  begin sum = dv + 1;      r = sum & 'hfff; cy = sum >> 12; m = 'b0111; end
      9:  begin sum = dv + 'hfff;  r = sum & 'hfff; cy = sum >> 12; m = 'b0111; end
      17: begin sum = ((~dv) & 'hfff) + 1; r = sum & 'hfff; cy = sum >> 12; m = 'b0111; end
      10, 11, 12, 13, 14: begin
        r = dv; cy = c; m = 'b0111;
        for (int i = 0; i < k; i++) begin
          int outb;
          case (o)
            10: begin outb = r & 1; r = (r >> 1) | (outb << 11); end
            11: begin outb = (r >> 11) & 1; r = ((r << 1) & 'hfff) | outb; end
            12: begin outb = r & 1; r = (r >> 1) | (cy << 11); end
            13: begin outb = (r >> 11) & 1; r = ((r << 1) & 'hfff) | cy; end
            default: begin outb = r & 1; r = (r >> 1) | (r & 'h800); end
          endcase
          cy = outb;
        end
      end
      15: begin
        cy = (dv >> 11) & 1;
        r = ((dv << 1) & 'hfff) | (((dv >> 11) ^ (dv >> 5) ^ (dv >> 3) ^ dv) & 1);
        m = 'b0111;
      end
      default: begin r = 0; wrv = 0; m = 0; end
    endcase
    if (o == 7 || o == 18) wrv = 0;
    return (r << 9) | (wrv << 8) | ((((v << 3) | (((r >> 11) & 1) << 2) | ((r == 0) << 1) | cy) & m) << 4) | m;
  endfunction

  function automatic string tag_of(int o, int k);
    if (o >= 10 && o <= 14 && k == 0) return "R12";
    case (o)
      0, 1, 2, 3, 16, 18: return "R2";
      4, 5:               return "R3";
      6, 7:               return "R4";
      8, 9, 17:           return "R5";
      10, 11:             return "R7";
      12, 13:             return "R8";
      14:                 return "R9";
      15:                 return "R10";
      default:            return "R1";
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s op=%0d d=%h s=%h c=%0d k=%0d got=%h exp=%h (res|wr|flags R6|mask)",
               tag, op, d, s, cin, mcnt, got, exp);
    end
  endtask

  task automatic apply(int o, int dv, int sv, int c, int l, int lv, int av, int e, string tovr);
    string tg;
    @(negedge clk);
    op = 5'(o); d = 12'(dv); s = 12'(sv); cin = 1'(c);
    ld = 1'(l); val = 4'(lv); aux = 4'(av); ex = 1'(e);
    #1;
    tg = (tovr != "") ? tovr : tag_of(o, mcnt);
    chk(tg, int'({res, wr, flags, mask}), pack_exp(o, dv, sv, c, mcnt));
    @(posedge clk);
    if (l != 0) mcnt = (lv == 0) ? av : lv;
    else if (e != 0 && o >= 10 && o <= 14) mcnt = 1;
  endtask

  initial begin
    #(200000.0 * 5.0);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int edges[4] = '{'h000, 'h7ff, 'h800, 'hfff};
    // reset state: MOV of zero while in reset
    #1;
    n_chk++;
    if ({res, wr, flags, mask} !== {12'h000, 1'b1, 4'b0010, 4'b0110}) begin
      n_err++;
      $display("FAIL R2 reset MOV got=%h exp=%h", {res, wr, flags, mask},
               {12'h000, 1'b1, 4'b0010, 4'b0110});
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: count after reset is 1
    apply(10, 'h001, 0, 0, 0, 0, 0, 1, "R11");
    // R11: explicit load, then consumed back to default
    apply(0, 0, 0, 0, 1, 3, 0, 0, "R2");
    apply(10, 'h001, 0, 0, 0, 0, 0, 1, "R11");
    apply(10, 'h001, 0, 0, 0, 0, 0, 1, "R11");
    // R11: zero selects aux
    apply(0, 0, 'h5a5, 0, 1, 0, 5, 0, "R2");
    apply(11, 'h801, 0, 1, 0, 0, 0, 1, "R11");
    // R11: rotate not executed keeps the count
    apply(0, 0, 0, 0, 1, 4, 0, 0, "R2");
    apply(14, 'h880, 0, 0, 0, 0, 0, 0, "R11");
    apply(14, 'h880, 0, 0, 0, 0, 0, 1, "R11");
    // R11: load wins over consume on the same edge
    apply(0, 0, 0, 0, 1, 2, 0, 0, "R2");
    apply(12, 'h003, 0, 1, 1, 7, 0, 1, "R11");
    apply(13, 'h003, 0, 1, 0, 0, 0, 1, "R11");
    // R12: count of zero from aux
    apply(0, 0, 0, 0, 1, 0, 0, 0, "R2");
    apply(12, 'h5a5, 0, 1, 0, 0, 0, 1, "R12");
    apply(0, 0, 0, 0, 1, 0, 0, 0, "R2");
    apply(10, 'h000, 0, 0, 0, 0, 0, 1, "R12");
    // signed boundary cross for every defined code
    for (int o = 0; o <= 18; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            apply(o, edges[i], edges[j], c, 0, 0, 0, 1, "");
    // R1: undefined codes
    for (int o = 19; o < 32; o++) apply(o, 'hfff, 'h123, 1, 0, 0, 0, 1, "R1");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int l = ($urandom_range(0, 3) == 0);
      apply($urandom_range(0, 31), $urandom_range(0, 4095), $urandom_range(0, 4095),
            $urandom_range(0, 1), l, $urandom_range(0, 15), $urandom_range(0, 15),
            ($urandom_range(0, 3) != 0), "");
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule